// File: doc/BRIEF.md
# Three-Phase Switch-Node Phase Error Detector

This block watches the three half-bridges of a motor bridge. For each phase it compares the commanded gate state with a digitised sense signal from the switch node. When exactly one transistor of a phase is commanded on, the switch node is expected to follow: high for the upper device and low for the lower device. Each new turn-on starts a per-phase window counter. The node level is sampled once, when the counter reaches the programmed deadtime. Sampling is suppressed when that instant still falls inside the programmed blanking interval.

A disagreement at the sampling instant gives a one-cycle error pulse on the matching per-phase output. The pulses are also OR-combined into a global phase error. Upper-side errors alone drive a desaturation indication. These pulses are meant to feed an external sticky status register.

Top module: `phase_err_det`

## Requirements
- R1: While rst_ni is low, every error output is 0.
- R2: If a phase is commanded upper-on only (hs=1, ls=0) and its sense input is 0 at the deadtime instant, that phase's hs_err_o bit goes to 1. The first rising edge that sees the new command is edge E0. The deadtime instant is edge E0+deadtime_i. The pulse is high between edges E0+deadtime_i and E0+deadtime_i+1.
- R3: If a phase is commanded lower-on only (hs=0, ls=1) and its sense input is 1 at the deadtime instant, that phase's ls_err_o bit pulses with the same timing as in R2.
- R4: If the sense level at the deadtime instant matches the drive (1 for upper-on, 0 for lower-on), no error is raised.
- R5: Each turn-on yields at most one error pulse, one cycle long, even if the mismatch persists.
- R6: The check is blanked when deadtime_i < blank_i, and then no error is raised. When deadtime_i equals blank_i, the check is made.
- R7: When a phase has both commands low, or both commands high, that phase raises no error.
- R8: phase_err_o is the OR of all per-phase upper and lower error bits. desat_o is the OR of the upper error bits only.
- R9: The sense level at cycles other than the deadtime instant has no effect.
- R10: Each change into upper-on or lower-on restarts the window, including a direct switch from one side to the other. If the command ends before the deadtime instant, no check is made.
- R11: A deadtime_i of 0 disables the check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hs_cmd_i | input | NUM_PH | Upper gate command per phase |
| ls_cmd_i | input | NUM_PH | Lower gate command per phase |
| sense_i | input | NUM_PH | Digitised switch-node level per phase |
| deadtime_i | input | CNT_W | Cycles from turn-on to the sampling instant |
| blank_i | input | CNT_W | Cycles after turn-on during which mismatches are ignored |
| hs_err_o | output | NUM_PH | Upper-side error pulse per phase |
| ls_err_o | output | NUM_PH | Lower-side error pulse per phase |
| phase_err_o | output | 1 | OR of all phase errors |
| desat_o | output | 1 | OR of upper-side errors |

## Verification
The error outputs go through one register. A mismatch at edge E0+deadtime_i therefore shows up after that edge and is gone after the next one. The bench applies each command half a period before E0. It then samples the packed output word at every falling edge through the window, expecting a nonzero word only after edge E0+deadtime_i. Tests that restart the window or move the sense level change inputs at falling edges at a known offset from E0, so each expected pulse cycle follows from R2 and R10 alone.

// File: rtl/phase_err_pkg.sv
package phase_err_pkg;
  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_HS   = 2'd1,
    DRV_LS   = 2'd2,
    DRV_BOTH = 2'd3
  } drv_e;

  function automatic drv_e drv_decode(input logic hs, input logic ls);
    return drv_e'({ls, hs});
  endfunction
endpackage

// File: rtl/phase_win_cnt.sv
module phase_win_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] deadtime_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             due_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign due_o = run_i && !restart_i && !done_q &&
                 (deadtime_i != '0) && (cnt_q == deadtime_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= CNT_ONE;
      done_q <= 1'b0;
    end else begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
      if (due_o) done_q <= 1'b1;
    end
  end

  // R10: a new turn-on always reloads the window
  a_r10_restart_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == CNT_ONE));
  // R5: sampling instant occurs once per window
  a_r5_due_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    due_o |=> !due_o);
endmodule

// File: rtl/phase_chk.sv
module phase_chk
  import phase_err_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_cmd_i,
  input  logic             ls_cmd_i,
  input  logic             sense_i,
  input  logic [CNT_W-1:0] deadtime_i,
  input  logic [CNT_W-1:0] blank_i,
  output logic             hs_err_o,
  output logic             ls_err_o
);
  drv_e             drv_now, drv_q;
  logic             active, restart, due, mismatch, fire;
  logic [CNT_W-1:0] cnt;

  assign drv_now  = drv_decode(hs_cmd_i, ls_cmd_i);
  assign active   = (drv_now == DRV_HS) || (drv_now == DRV_LS);
  assign restart  = active && (drv_now != drv_q);
  // node expected high when upper device on, low when lower device on
  assign mismatch = sense_i ^ (drv_now == DRV_HS);
  assign fire     = due && (cnt >= blank_i) && mismatch;

  phase_win_cnt #(.CNT_W(CNT_W)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (active),
    .restart_i  (restart),
    .deadtime_i (deadtime_i),
    .cnt_o      (cnt),
    .due_o      (due)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q    <= DRV_OFF;
      hs_err_o <= 1'b0;
      ls_err_o <= 1'b0;
    end else begin
      drv_q    <= drv_now;
      hs_err_o <= fire && (drv_now == DRV_HS);
      ls_err_o <= fire && (drv_now == DRV_LS);
    end
  end

  a_r2_hs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_err_o |-> $past(hs_cmd_i && !ls_cmd_i && !sense_i));
  a_r3_ls_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_err_o |-> $past(ls_cmd_i && !hs_cmd_i && sense_i));
  a_r7_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_cmd_i == ls_cmd_i) |=> !(hs_err_o || ls_err_o));
  a_r5_hs_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_err_o |=> !hs_err_o);
  a_r5_ls_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_err_o |=> !ls_err_o);
endmodule

// File: rtl/phase_err_det.sv
module phase_err_det #(
  parameter int NUM_PH = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PH-1:0] hs_cmd_i,
  input  logic [NUM_PH-1:0] ls_cmd_i,
  input  logic [NUM_PH-1:0] sense_i,
  input  logic [CNT_W-1:0]  deadtime_i,
  input  logic [CNT_W-1:0]  blank_i,
  output logic [NUM_PH-1:0] hs_err_o,
  output logic [NUM_PH-1:0] ls_err_o,
  output logic              phase_err_o,
  output logic              desat_o
);
  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    phase_chk #(.CNT_W(CNT_W)) u_chk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hs_cmd_i   (hs_cmd_i[p]),
      .ls_cmd_i   (ls_cmd_i[p]),
      .sense_i    (sense_i[p]),
      .deadtime_i (deadtime_i),
      .blank_i    (blank_i),
      .hs_err_o   (hs_err_o[p]),
      .ls_err_o   (ls_err_o[p])
    );
  end

  assign phase_err_o = |{hs_err_o, ls_err_o};
  assign desat_o     = |hs_err_o;

  a_r8_desat_in_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desat_o |-> phase_err_o);
  a_r11_zero_dt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deadtime_i == '0) && $stable(deadtime_i) |=> !phase_err_o);
  always_comb begin
    if (rst_ni === 1'b0) a_r1_reset_quiet: assert (!phase_err_o && !desat_o);
  end
endmodule

// File: tb/phase_err_det_test.sv
`timescale 1ns/1ps
module phase_err_det_test;
  localparam int NP = 3;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] hs = '0, ls = '0, sns = '0;
  logic [CW-1:0] dt = '0, bl = '0;
  logic [NP-1:0] hs_err, ls_err;
  logic          ph_err, desat;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  phase_err_det #(.NUM_PH(NP), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hs_cmd_i(hs), .ls_cmd_i(ls), .sense_i(sns),
    .deadtime_i(dt), .blank_i(bl), .hs_err_o(hs_err), .ls_err_o(ls_err),
    .phase_err_o(ph_err), .desat_o(desat)
  );

  // word layout: {desat, phase_err, ls_err[2:0], hs_err[2:0]}
  function automatic logic [7:0] word(input logic [2:0] h, input logic [2:0] l);
    return {|h, |{h, l}, l, h};
  endfunction

  task automatic chk(input string tag, input logic [7:0] exp);
    logic [7:0] act;
    act = {desat, ph_err, ls_err, hs_err};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%02h exp=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    hs = '0; ls = '0; sns = '0;
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]    ph;
    logic          h, l, s;
    logic [CW-1:0] d, b;
    logic          eh, el;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b1, 1'b0, 1'b0, 8'd3, 8'd0, 1'b1, 1'b0}, // R2
    '{2'd1, 1'b0, 1'b1, 1'b1, 8'd4, 8'd2, 1'b0, 1'b1}, // R3
    '{2'd2, 1'b1, 1'b0, 1'b1, 8'd2, 8'd1, 1'b0, 1'b0}, // R4
    '{2'd0, 1'b0, 1'b1, 1'b0, 8'd5, 8'd0, 1'b0, 1'b0}, // R4
    '{2'd1, 1'b1, 1'b0, 1'b0, 8'd2, 8'd5, 1'b0, 1'b0}, // R6 blanked
    '{2'd2, 1'b1, 1'b1, 1'b0, 8'd2, 8'd0, 1'b0, 1'b0}, // R7 both on
    '{2'd2, 1'b0, 1'b0, 1'b1, 8'd2, 8'd0, 1'b0, 1'b0}, // R7 both off
    '{2'd2, 1'b0, 1'b1, 1'b1, 8'd1, 8'd1, 1'b0, 1'b1}, // R6 dt==blank, R3
    '{2'd1, 1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0}  // R11
  };

  initial begin
    // R1
    repeat (3) @(negedge clk);
    chk("R1 reset", 8'h00);
    rst_n = 1'b1;
    idle(2);
    chk("R1 after release", 8'h00);

    // table walk: R2 R3 R4 R6 R7 R8 R11
    for (int v = 0; v < NV; v++) begin
      dt = VECS[v].d; bl = VECS[v].b;
      hs[VECS[v].ph] = VECS[v].h;
      ls[VECS[v].ph] = VECS[v].l;
      sns[VECS[v].ph] = VECS[v].s;
      for (int i = 0; i <= int'(VECS[v].d) + 3; i++) begin
        logic [2:0] eh3, el3;
        @(negedge clk);
        eh3 = '0; el3 = '0;
        if (i == int'(VECS[v].d)) begin
          eh3[VECS[v].ph] = VECS[v].eh;
          el3[VECS[v].ph] = VECS[v].el;
        end
        chk($sformatf("R2/R3/R4/R6/R7/R8/R11 vec%0d cyc%0d", v, i), word(eh3, el3));
      end
      idle(2);
    end

    // R5: persistent mismatch yields one pulse
    dt = 8'd2; bl = 8'd0;
    hs[1] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk("R5 single pulse", (i == 2) ? word(3'b010, 3'b000) : 8'h00);
    end
    idle(2);

    // R9: sense correct only at the sampling instant
    dt = 8'd4; bl = 8'd0;
    hs[0] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R9 sense off-instant ignored", 8'h00);
      sns[0] = (i == 3);
    end
    idle(2);

    // R10: command ends before the instant
    dt = 8'd5; bl = 8'd0;
    hs[2] = 1'b1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      chk("R10 early drop", 8'h00);
      if (i == 2) hs[2] = 1'b0;
    end
    idle(2);

    // R10: direct upper->lower switch restarts the window
    dt = 8'd3; bl = 8'd0;
    hs[0] = 1'b1; sns[0] = 1'b1;
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      chk("R10 side switch restart", (i == 9) ? word(3'b000, 3'b001) : 8'h00);
      if (i == 5) begin hs[0] = 1'b0; ls[0] = 1'b1; end
    end
    idle(2);

    // R1: reset during an active window
    dt = 8'd3;
    ls[1] = 1'b1; sns[1] = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 reset mid-window", 8'h00);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule